// File: doc/BRIEF.md
# Serial Debug Monitor Command Engine

This block turns a stream of received bytes from a host into single-byte accesses on a memory bus. It sits between a byte receiver and a byte transmitter, neither of which is part of the block. Each incoming byte comes with a valid strobe, and a separate input flags a line break. The engine keeps a 16-bit address pointer that persists from one command to the next. It performs reads and writes through a request/acknowledge handshake. Response bytes go into a small FIFO that the transmitter drains.

The host sends a one-byte opcode and then the operand bytes that opcode needs. The engine echoes every command and operand byte before acting on it. It can:
- load the pointer and read or write at that address;
- step the pointer forward with the indexed commands;
- report a stack pointer value, which is supplied on an input;
- hand control to user code.

A break from the host, or an opcode the engine does not know, makes the engine request a break on the transmit side and return to waiting for an opcode.

Top module: `dbgmon_engine`

## Requirements
- R1: After reset `tx_valid`, `mem_req`, `run_active` and `tx_break` are all 0, and the engine waits for an opcode.
- R2: Each byte accepted while the engine waits for an opcode, an address byte or a data byte is pushed unchanged into the response FIFO, ahead of any response that byte causes.
- R3: Opcode 0x4A, then address high byte, then address low byte, loads the pointer and returns the memory byte at that address.
- R4: Opcode 0x49, then address high byte, address low byte and one data byte, loads the pointer and writes the data byte at that address.
- R5: Opcode 0x1A returns the byte at pointer+1 and then the byte at pointer+2, and leaves the pointer 2 higher.
- R6: Opcode 0x19 takes one data byte, adds 1 to the pointer, and writes the byte at the new pointer value.
- R7: Opcode 0x0C returns `sp_value[15:8]` and then `sp_value[7:0]`, with no memory access.
- R8: Any other opcode raises `tx_break` for one cycle, starts no memory access, and returns the engine to opcode wait.
- R9: `rx_break` while a command is in progress raises `tx_break` once and drops the command; the next byte is taken as an opcode. A memory access already requested is finished first.
- R10: Opcode 0x28 sets `run_active`. While it is set, received bytes are neither echoed nor acted on. `run_exit` clears it and returns the engine to opcode wait.
- R11: Once raised, `mem_req` stays high with a steady address until the cycle `mem_ack` is seen, and is low in the cycle after.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition detected on the receive line |
| sp_value | input | 16 | Stack pointer value reported by opcode 0x0C |
| run_exit | input | 1 | Re-entry into command mode |
| run_active | output | 1 | User code is running |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 8 | Read data |
| tx_valid | output | 1 | Response FIFO holds a byte |
| tx_data | output | 8 | Byte at the head of the FIFO |
| tx_ready | input | 1 | Transmitter takes the head byte |
| tx_break | output | 1 | One-cycle request to transmit a break |

## Verification
A stale or miscounted pointer appears at the memory port as a wrong address on the very next indexed command. For that reason the indexed tests are chained: an indexed read is followed by an indexed write, and the address of that write is checked. A parser that lost its place shows within one byte: either an echo is missing, or an extra response byte reaches `tx_data` a few cycles after the operand. A stuck break or run state shows as the missing echo of the following opcode. The bench therefore sends a known command straight after every break, unknown opcode and run exit.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 16;

  localparam logic [7:0] OP_RD  = 8'h4A;
  localparam logic [7:0] OP_WR  = 8'h49;
  localparam logic [7:0] OP_IRD = 8'h1A;
  localparam logic [7:0] OP_IWR = 8'h19;
  localparam logic [7:0] OP_SP  = 8'h0C;
  localparam logic [7:0] OP_RUN = 8'h28;

  typedef enum logic [2:0] {
    K_RD, K_WR, K_IRD, K_IWR, K_SP, K_RUN, K_BAD
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_AHI, S_ALO, S_DATA, S_MEM, S_PUSH, S_RUN
  } eng_state_e;
endpackage

// File: rtl/dbgmon_decode.sv
module dbgmon_decode
  import dbgmon_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output op_kind_e          kind_o
);
  always_comb begin
    unique case (op_i)
      OP_RD:   kind_o = K_RD;
      OP_WR:   kind_o = K_WR;
      OP_IRD:  kind_o = K_IRD;
      OP_IWR:  kind_o = K_IWR;
      OP_SP:   kind_o = K_SP;
      OP_RUN:  kind_o = K_RUN;
      default: kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/dbgmon_fifo.sv
module dbgmon_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] head_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign head_o  = store[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dbgmon_ctrl.sv
module dbgmon_ctrl
  import dbgmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_break_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              run_exit_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] push_data_o,
  output logic              run_o,
  output logic              brk_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  eng_state_e        st_q;
  op_kind_e          cmd_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] resp_q;
  logic              second_q;
  logic              brk_pend_q;
  logic              collecting, echo;

  assign collecting = (st_q == S_IDLE) || (st_q == S_AHI) ||
                      (st_q == S_ALO)  || (st_q == S_DATA);
  assign echo       = collecting && rx_valid_i && !rx_break_i;

  always_comb begin
    push_o      = 1'b0;
    push_data_o = resp_q;
    if (echo) begin
      push_o      = 1'b1;
      push_data_o = rx_data_i;
    end else if (st_q == S_PUSH && !rx_break_i) begin
      push_o = !fifo_full_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      cmd_q       <= K_BAD;
      ptr_q       <= '0;
      resp_q      <= '0;
      second_q    <= 1'b0;
      brk_pend_q  <= 1'b0;
      run_o       <= 1'b0;
      brk_o       <= 1'b0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      brk_o <= 1'b0;
      if (mem_req_o && mem_ack_i) mem_req_o <= 1'b0;

      if (rx_break_i && st_q != S_RUN && st_q != S_MEM) begin
        brk_o <= 1'b1;
        st_q  <= S_IDLE;
      end else begin
        unique case (st_q)
          S_IDLE: if (rx_valid_i) begin
            cmd_q    <= kind_i;
            second_q <= 1'b0;
            unique case (kind_i)
              K_RD, K_WR: st_q <= S_AHI;
              K_IWR:      st_q <= S_DATA;
              K_IRD: begin
                mem_req_o  <= 1'b1;
                mem_we_o   <= 1'b0;
                mem_addr_o <= ptr_q + 1'b1;
                st_q       <= S_MEM;
              end
              K_SP: begin
                resp_q <= sp_i[ADDR_W-1 -: BYTE_W];
                st_q   <= S_PUSH;
              end
              K_RUN: begin
                run_o <= 1'b1;
                st_q  <= S_RUN;
              end
              default: brk_o <= 1'b1;
            endcase
          end
          S_AHI: if (rx_valid_i) begin
            ptr_q[ADDR_W-1 -: BYTE_W] <= rx_data_i;
            st_q <= S_ALO;
          end
          S_ALO: if (rx_valid_i) begin
            ptr_q[BYTE_W-1:0] <= rx_data_i;
            if (cmd_q == K_RD) begin
              mem_req_o  <= 1'b1;
              mem_we_o   <= 1'b0;
              mem_addr_o <= {ptr_q[ADDR_W-1 -: BYTE_W], rx_data_i};
              st_q       <= S_MEM;
            end else begin
              st_q <= S_DATA;
            end
          end
          S_DATA: if (rx_valid_i) begin
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_wdata_o <= rx_data_i;
            st_q        <= S_MEM;
            if (cmd_q == K_IWR) begin
              ptr_q      <= ptr_q + 1'b1;
              mem_addr_o <= ptr_q + 1'b1;
            end else begin
              mem_addr_o <= ptr_q;
            end
          end
          S_MEM: begin
            if (rx_break_i) brk_pend_q <= 1'b1;
            if (mem_ack_i) begin
              if (brk_pend_q || rx_break_i) begin
                brk_o      <= 1'b1;
                brk_pend_q <= 1'b0;
                st_q       <= S_IDLE;
              end else if (mem_we_o) begin
                st_q <= S_IDLE;
              end else begin
                resp_q <= mem_rdata_i;
                st_q   <= S_PUSH;
              end
            end
          end
          S_PUSH: if (!fifo_full_i) begin
            if (cmd_q == K_IRD) begin
              ptr_q <= ptr_q + 1'b1;
              if (!second_q) begin
                second_q   <= 1'b1;
                mem_req_o  <= 1'b1;
                mem_we_o   <= 1'b0;
                mem_addr_o <= ptr_q + 2'd2;
                st_q       <= S_MEM;
              end else begin
                st_q <= S_IDLE;
              end
            end else if (cmd_q == K_SP && !second_q) begin
              second_q <= 1'b1;
              resp_q   <= sp_i[BYTE_W-1:0];
            end else begin
              st_q <= S_IDLE;
            end
          end
          S_RUN: if (run_exit_i) begin
            run_o <= 1'b0;
            st_q  <= S_IDLE;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbgmon_engine.sv
module dbgmon_engine
  import dbgmon_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  input  logic [15:0] sp_value,
  input  logic        run_exit,
  output logic        run_active,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic [7:0]  mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        tx_break
);
  op_kind_e          kind;
  logic              push, full;
  logic [BYTE_W-1:0] push_data;

  dbgmon_decode u_dec (.op_i(rx_data), .kind_o(kind));

  dbgmon_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .kind_i(kind), .sp_i(sp_value), .run_exit_i(run_exit),
    .fifo_full_i(full), .push_o(push), .push_data_o(push_data),
    .run_o(run_active), .brk_o(tx_break),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  dbgmon_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push_i(push), .push_data_i(push_data),
    .pop_i(tx_ready), .full_o(full),
    .valid_o(tx_valid), .head_o(tx_data)
  );
endmodule

// File: rtl/dbgmon_engine_chk.sv
module dbgmon_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_valid,
  input logic [7:0]  rx_data,
  input logic        run_active,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R11
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> !mem_req); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
  AST_RUN_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    run_active && !$rose(run_active) |-> !mem_req); // R10
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(run_active) |-> $past(rx_valid && rx_data == 8'h28)); // R10
endmodule

bind dbgmon_engine dbgmon_engine_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
  .run_active(run_active), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready)
);

// File: tb/dbgmon_engine_tb_top.sv
`timescale 1ns/1ps
module dbgmon_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_break = 1'b0, run_exit = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [15:0] sp_value = 16'hBEEF;
  logic        run_active, mem_req, mem_we, tx_valid, tx_break;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, tx_data;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        tx_ready = 1'b1;

  always #2.5 clk = ~clk;

  dbgmon_engine dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .sp_value(sp_value), .run_exit(run_exit),
    .run_active(run_active), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_break(tx_break)
  );

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0]  mem [256];
  logic [7:0]  got [64];
  int          ngot = 0, nbrk = 0, nwr = 0, nacc = 0;
  logic [15:0] last_wr_addr = '0;
  logic [7:0]  last_wr_data = '0;

  always @(negedge clk) begin
    cycles++;
    if (tx_valid && tx_ready && ngot < 64) begin got[ngot] = tx_data; ngot++; end
    if (tx_break) nbrk++;
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      nacc++;
      mem_rdata = mem[mem_addr[7:0]];
      if (mem_we) begin
        mem[mem_addr[7:0]] = mem_wdata;
        last_wr_addr = mem_addr; last_wr_data = mem_wdata; nwr++;
      end
    end else mem_ack = 1'b0;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_break();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic clear_log();
    ngot = 0; nbrk = 0; nwr = 0; nacc = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 run_active", run_active, 0);
    chk("R1 tx_break", tx_break, 0);
  endtask

  task automatic t_write();
    clear_log();
    send(8'h49); send(8'h12); send(8'h34); send(8'h5A);
    chk("R2 echo count", ngot, 4);
    chk("R2 echo op", got[0], 8'h49);
    chk("R2 echo data", got[3], 8'h5A);
    chk("R4 write addr", last_wr_addr, 16'h1234);
    chk("R4 write data", last_wr_data, 8'h5A);
  endtask

  task automatic t_read();
    clear_log();
    send(8'h4A); send(8'h12); send(8'h34);
    chk("R3 byte count", ngot, 4);
    chk("R2 echo before resp", got[2], 8'h34);
    chk("R3 read data", got[3], 8'h5A);
  endtask

  task automatic t_iwrite_iread();
    clear_log();
    send(8'h19); send(8'h77);
    chk("R6 write addr", last_wr_addr, 16'h1235);
    chk("R6 write data", last_wr_data, 8'h77);
    mem[8'h36] = 8'hC1; mem[8'h37] = 8'hD2;
    clear_log();
    send(8'h1A);
    chk("R5 byte count", ngot, 3);
    chk("R5 first", got[1], 8'hC1);
    chk("R5 second", got[2], 8'hD2);
    send(8'h19); send(8'h99);
    chk("R5 pointer advanced by 2 (R6 next)", last_wr_addr, 16'h1238);
  endtask

  task automatic t_sp();
    clear_log();
    send(8'h0C);
    chk("R7 byte count", ngot, 3);
    chk("R7 high", got[1], 8'hBE);
    chk("R7 low", got[2], 8'hEF);
    chk("R7 no memory access", nacc, 0);
  endtask

  task automatic t_unknown();
    clear_log();
    send(8'h55);
    chk("R8 break pulses", nbrk, 1);
    chk("R8 echo only", ngot, 1);
    chk("R8 no memory access", nacc, 0);
    send(8'h0C);
    chk("R8 back to opcode wait", ngot, 4);
  endtask

  task automatic t_break();
    clear_log();
    send(8'h4A); send(8'h12);
    send_break();
    chk("R9 break pulses", nbrk, 1);
    chk("R9 no memory access", nacc, 0);
    send(8'h0C);
    chk("R9 next byte is opcode", ngot, 5);
    chk("R9 sp high after abort", got[3], 8'hBE);
  endtask

  task automatic t_run();
    clear_log();
    send(8'h28);
    chk("R10 run set", run_active, 1);
    chk("R10 echo of run", ngot, 1);
    send(8'h4A); send(8'h12); send(8'h34);
    chk("R10 bytes ignored while running", ngot, 1);
    chk("R10 no memory while running", nacc, 0);
    @(negedge clk); run_exit = 1'b1;
    @(negedge clk); run_exit = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 run cleared", run_active, 0);
    send(8'h0C);
    chk("R10 commands resume", ngot, 4);
  endtask

  task automatic t_backpressure();
    clear_log();
    tx_ready = 1'b0;
    send(8'h0C);
    chk("R12 held valid", tx_valid, 1);
    chk("R12 head byte", tx_data, 8'h0C);
    tx_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 drained count", ngot, 3);
    chk("R12 drained low", got[2], 8'hEF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hA5);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_iwrite_iread();
    t_sp();
    t_unknown();
    t_break();
    t_run();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule